// File: doc/BRIEF.md
# Processor Sleep Controller

This block puts a small processor core into a low-power state and brings it back. Software arms it through three 8-bit control registers on a simple write/read bus: one bit enables sleep, and three select bits, spread over those three registers, choose idle, power-down or standby. When the core issues its one-cycle sleep strobe with sleep enabled, the controller halts the core and gates the clock domains that the chosen mode switches off.

An enabled interrupt wakes the core. In power-down the oscillator is stopped as well, so the controller first waits for the clock source's start-up-done signal. In idle and standby the oscillator keeps running and there is no start-up wait. In every mode the core then stays halted for four further cycles with its clocks running, and resumes at the instruction after the sleep instruction. A reset at any time returns the controller to running and points the resume selector at the reset vector. Register-file and memory contents are never touched: the controller has no clear output.

Top module: `sleep_ctrl`

## Requirements
- R1: While and after reset all three control registers read 0x00, the core is not halted, every clock enable is 1 and `resume_at_reset` is 1.
- R2: Address 0 holds the enable bit at bit 5 and select bit 1 at bit 4; address 1 holds select bit 2 at bit 5; address 2 holds select bit 0 at bit 7. All eight bits of these registers are writable and read back. Address 3 reads 0x00 and writes to it change nothing.
- R3: A sleep strobe in the running state with the enable bit at 1 halts the core (`core_halt` 1, `cpu_clk_en` 0) from the following cycle. With the enable bit at 0 the strobe has no effect.
- R4: The select code {bit2,bit1,bit0} 010 is power-down, 110 is standby and every other code is idle; the code is taken at the sleep strobe.
- R5: During sleep, idle turns off only `cpu_clk_en`; standby also turns off all `io_clk_en` bits; power-down also drives `osc_en` to 0.
- R6: In idle or standby, an interrupt during sleep is followed by exactly four cycles with the core halted and all other clocks on, then the core runs.
- R7: In power-down, an interrupt turns `osc_en` on while the core stays halted and the other domains stay off until `osc_ready` is seen at 1; then the four-cycle halt of R6 follows.
- R8: `resume_at_reset` falls to 0 when an interrupt wake finishes and keeps its value while sleeping and running.
- R9: An interrupt while running, and a sleep strobe while not running, have no effect.
- R10: Sleep and wake leave the control register contents unchanged.
- R11: A reset during sleep, even in the same cycle as an interrupt, returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sleep_req | input | 1 | One-cycle sleep-instruction strobe from the core |
| irq_wake | input | 1 | An enabled interrupt is pending |
| osc_ready | input | 1 | Oscillator start-up complete |
| core_halt | output | 1 | Core is held halted |
| cpu_clk_en | output | 1 | Core clock enable |
| io_clk_en | output | N_DOMAINS | Peripheral clock domain enables |
| osc_en | output | 1 | Oscillator run enable |
| resume_at_reset | output | 1 | 1: resume at reset vector, 0: next instruction |

## Verification
On every cycle the assertions hold the state transitions locally: a strobe with the enable bit clear leaves the core running, a strobe with it set halts it, the halt window cannot be cut short, start-up waits for `osc_ready`, the resume selector only falls at the end of a wake, registers hold without a write, and a stopped oscillator always comes with halted core and gated domains. Only the bench's scenarios show the complete mode decoding from the three scattered bits, the exact four-cycle wake length seen at the ports, the gating mix of each mode, and that a reset mid-sleep clears registers and selector together.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    // bit positions decoded by the controller
    localparam int EN_POS   = 5;  // address 0
    localparam int SEL1_POS = 4;  // address 0
    localparam int SEL2_POS = 5;  // address 1
    localparam int SEL0_POS = 7;  // address 2

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_EXT  = 2'd2;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_STARTUP,
        ST_HALT
    } slp_state_e;

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_PDOWN,
        MODE_STBY
    } slp_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] ext;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] ctrl;
    } reg_bank_t;

    function automatic slp_mode_e decode_mode(input logic [2:0] sel);
        case (sel)
            3'b010:  return MODE_PDOWN;
            3'b110:  return MODE_STBY;
            default: return MODE_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/sleep_regs.sv
module sleep_regs
    import sleep_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sleep_en,
    output logic [2:0]        mode_sel
);

    reg_bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (addr)
                A_CTRL:  bank_d.ctrl = wdata;
                A_STAT:  bank_d.stat = wdata;
                A_EXT:   bank_d.ext  = wdata;
                default: bank_d = bank_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = bank_q.ctrl;
            A_STAT:  rdata = bank_q.stat;
            A_EXT:   rdata = bank_q.ext;
            default: rdata = '0;
        endcase
    end

    assign sleep_en = bank_q.ctrl[EN_POS];
    assign mode_sel = {bank_q.stat[SEL2_POS], bank_q.ctrl[SEL1_POS], bank_q.ext[SEL0_POS]};

    // R10: contents only move on a write
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q));

    // R2: the unused address is not backed by storage
    p_addr3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=> $stable(bank_q));

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import sleep_ctrl_pkg::*;
#(
    parameter int HALT_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_en,
    input  logic [2:0] mode_sel,
    input  logic       sleep_req,
    input  logic       irq_wake,
    input  logic       osc_ready,
    output slp_state_e state,
    output slp_mode_e  mode,
    output logic       resume_at_reset
);

    localparam int CNT_W = (HALT_CYCLES > 1) ? $clog2(HALT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALT_CYCLES - 1);

    typedef struct packed {
        slp_state_e       state;
        logic [CNT_W-1:0] cnt;
        slp_mode_e        mode;
        logic             resume;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.state)
            ST_RUN: begin
                if (sleep_req && sleep_en) begin
                    fsm_d.state = ST_SLEEP;
                    fsm_d.mode  = decode_mode(mode_sel);
                end
            end
            ST_SLEEP: begin
                if (irq_wake) begin
                    fsm_d.cnt = '0;
                    if (fsm_q.mode == MODE_PDOWN) fsm_d.state = ST_STARTUP;
                    else                          fsm_d.state = ST_HALT;
                end
            end
            ST_STARTUP: begin
                if (osc_ready) begin
                    fsm_d.state = ST_HALT;
                    fsm_d.cnt   = '0;
                end
            end
            ST_HALT: begin
                if (fsm_q.cnt == CNT_LAST) begin
                    fsm_d.state  = ST_RUN;
                    fsm_d.resume = 1'b0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            default: fsm_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state  <= ST_RUN;
            fsm_q.cnt    <= '0;
            fsm_q.mode   <= MODE_IDLE;
            fsm_q.resume <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state           = fsm_q.state;
    assign mode            = fsm_q.mode;
    assign resume_at_reset = fsm_q.resume;

    // R3: strobe without enable keeps the core running
    p_no_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_RUN && sleep_req && !sleep_en) |=> fsm_q.state == ST_RUN);

    // R3: strobe with enable enters sleep
    p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_RUN && sleep_req && sleep_en) |=> fsm_q.state == ST_SLEEP);

    // R6: halt window is not cut short
    p_halt_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_HALT && fsm_q.cnt != CNT_LAST) |=> fsm_q.state == ST_HALT);

    // R7: start-up waits for the oscillator
    p_startup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_STARTUP && !osc_ready) |=> fsm_q.state == ST_STARTUP);

    // R8: selector only falls at the end of a wake
    p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fsm_q.resume) |-> $past(fsm_q.state) == ST_HALT);

    // R9: interrupt while running does nothing
    p_run_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_RUN && !sleep_req) |=> fsm_q.state == ST_RUN);

endmodule

// File: rtl/sleep_gate.sv
module sleep_gate
    import sleep_ctrl_pkg::*;
#(
    parameter int N_DOMAINS = 2
) (
    input  slp_state_e           state,
    input  slp_mode_e            mode,
    output logic                 core_halt,
    output logic                 cpu_clk_en,
    output logic [N_DOMAINS-1:0] io_clk_en,
    output logic                 osc_en
);

    logic asleep;
    logic io_off;

    always_comb begin
        asleep     = (state == ST_SLEEP) || (state == ST_STARTUP);
        io_off     = asleep && (mode != MODE_IDLE);
        core_halt  = (state != ST_RUN);
        cpu_clk_en = (state == ST_RUN);
        osc_en     = !((state == ST_SLEEP) && (mode == MODE_PDOWN));
    end

    for (genvar g = 0; g < N_DOMAINS; g++) begin : g_dom
        assign io_clk_en[g] = !io_off;
    end

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import sleep_ctrl_pkg::*;
#(
    parameter int HALT_CYCLES = 4,
    parameter int N_DOMAINS   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic                 sleep_req,
    input  logic                 irq_wake,
    input  logic                 osc_ready,
    output logic                 core_halt,
    output logic                 cpu_clk_en,
    output logic [N_DOMAINS-1:0] io_clk_en,
    output logic                 osc_en,
    output logic                 resume_at_reset
);

    logic       sleep_en;
    logic [2:0] mode_sel;
    slp_state_e state;
    slp_mode_e  mode;

    sleep_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .sleep_en (sleep_en),
        .mode_sel (mode_sel)
    );

    sleep_fsm #(.HALT_CYCLES(HALT_CYCLES)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .sleep_en        (sleep_en),
        .mode_sel        (mode_sel),
        .sleep_req       (sleep_req),
        .irq_wake        (irq_wake),
        .osc_ready       (osc_ready),
        .state           (state),
        .mode            (mode),
        .resume_at_reset (resume_at_reset)
    );

    sleep_gate #(.N_DOMAINS(N_DOMAINS)) u_gate (
        .state      (state),
        .mode       (mode),
        .core_halt  (core_halt),
        .cpu_clk_en (cpu_clk_en),
        .io_clk_en  (io_clk_en),
        .osc_en     (osc_en)
    );

    // R5: a stopped oscillator always comes with a halted core and gated domains
    p_osc_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (core_halt && io_clk_en == '0));

endmodule

// File: tb/sleep_ctrl_tb.sv
module sleep_ctrl_tb;

    localparam int ND = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [7:0]    bus_wdata = 8'd0;
    logic [7:0]    bus_rdata;
    logic          sleep_req = 1'b0;
    logic          irq_wake = 1'b0;
    logic          osc_ready = 1'b0;
    logic          core_halt, cpu_clk_en, osc_en, resume_at_reset;
    logic [ND-1:0] io_clk_en;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    sleep_ctrl #(.HALT_CYCLES(4), .N_DOMAINS(ND)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
        .irq_wake(irq_wake), .osc_ready(osc_ready), .core_halt(core_halt),
        .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .osc_en(osc_en),
        .resume_at_reset(resume_at_reset)
    );

    // behavioural reference: phase 0 run, 1 asleep, 2 waiting oscillator, 3 halted countdown
    logic [7:0] m_reg [3] = '{8'h00, 8'h00, 8'h00};
    int m_phase = 0;
    int m_left = 0;
    int m_kind = 0;   // 0 idle, 1 power-down, 2 standby
    bit m_resume = 1'b1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg = '{8'h00, 8'h00, 8'h00};
            m_phase = 0; m_left = 0; m_kind = 0; m_resume = 1'b1;
        end else begin
            bit en;
            int code;
            en = m_reg[0][5];
            code = {m_reg[1][5], m_reg[0][4], m_reg[2][7]};
            if (m_phase == 0) begin
                if (sleep_req && en) begin
                    m_phase = 1;
                    m_kind = (code == 2) ? 1 : (code == 6) ? 2 : 0;
                end
            end else if (m_phase == 1) begin
                if (irq_wake) begin
                    m_phase = (m_kind == 1) ? 2 : 3;
                    m_left = 4;
                end
            end else if (m_phase == 2) begin
                if (osc_ready) begin m_phase = 3; m_left = 4; end
            end else begin
                m_left--;
                if (m_left == 0) begin m_phase = 0; m_resume = 1'b0; end
            end
            if (bus_wr && bus_addr != 2'd3) m_reg[bus_addr] = bus_wdata;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit halted, io_on, osc_on;
        halted = (m_phase != 0);
        io_on  = !((m_phase == 1 || m_phase == 2) && m_kind != 0);
        osc_on = !(m_phase == 1 && m_kind == 1);
        chk("core_halt", 32'(core_halt), 32'(halted));
        chk("cpu_clk_en", 32'(cpu_clk_en), 32'(!halted));
        chk("io_clk_en", 32'(io_clk_en), io_on ? 32'(2'b11) : 32'd0);
        chk("osc_en", 32'(osc_en), 32'(osc_on));
        chk("resume_at_reset", 32'(resume_at_reset), 32'(m_resume));
        chk("bus_rdata", 32'(bus_rdata), (bus_addr == 2'd3) ? 32'd0 : 32'(m_reg[bus_addr]));
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #0.5;
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic sleep_now();
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
    endtask

    task automatic wake();
        irq_wake = 1'b1; step(); irq_wake = 1'b0;
    endtask

    task automatic set_mode(logic s2, logic s1, logic s0);
        wr(2'd0, {2'b00, 1'b1, s1, 4'h0});
        wr(2'd1, {2'b00, s2, 5'h00});
        wr(2'd2, {s0, 7'h00});
    endtask

    initial begin
        cur_req = "R1";
        step(3);
        rst_n = 1'b1;
        step(2);

        cur_req = "R2";
        wr(2'd0, 8'hA5); wr(2'd1, 8'h5A); wr(2'd2, 8'hFF);
        wr(2'd3, 8'h77);
        for (int a = 0; a < 4; a++) begin bus_addr = 2'(a); step(); end
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

        cur_req = "R3";
        wr(2'd0, 8'hDF);            // every bit but the enable
        sleep_now(); step(2);

        cur_req = "R9";
        wake(); step(2);

        cur_req = "R6";
        set_mode(1'b0, 1'b0, 1'b0);
        bus_addr = 2'd0;
        sleep_now(); step(3); wake(); step(7);

        cur_req = "R5";
        set_mode(1'b1, 1'b1, 1'b0);   // standby
        sleep_now(); step(3);
        cur_req = "R9";
        sleep_now(); step(2);
        cur_req = "R6";
        wake(); step(7);

        cur_req = "R7";
        set_mode(1'b0, 1'b1, 1'b0);   // power-down
        bus_addr = 2'd2;
        sleep_now(); step(3); wake(); step(5);
        osc_ready = 1'b1; step(); osc_ready = 1'b0;
        step(6);

        cur_req = "R4";
        set_mode(1'b1, 1'b1, 1'b1);   // unused code acts as idle
        sleep_now(); step(3); wake(); step(6);
        set_mode(1'b0, 1'b0, 1'b1);
        sleep_now(); step(2); wake(); step(6);

        cur_req = "R10";
        for (int a = 0; a < 3; a++) begin bus_addr = 2'(a); step(); end

        cur_req = "R8";
        step(2);

        cur_req = "R11";
        set_mode(1'b0, 1'b1, 1'b0);
        sleep_now(); step(2); wake(); step(2);
        irq_wake = 1'b1; #0.5 rst_n = 1'b0;
        step(2);
        irq_wake = 1'b0; rst_n = 1'b1;
        for (int a = 0; a < 3; a++) begin bus_addr = 2'(a); step(); end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule